// File: doc/BRIEF.md
# Parallel Panel Write Interface (8080-style)

This block sends pixel words to a display panel that keeps its own frame memory, over an 8080-style parallel write bus with a chip select, a write strobe, a register-select line and a data bus. Each word goes through four phases, and each phase has its own length set by software. The chip select drops first. The data is then set up on the bus, the write strobe pulses low, and data and chip select stay put for a hold time after the strobe rises.

Software writes the phase lengths and an enable bit into a timing register. It then sets a mode bit and a one-shot trigger bit in a trigger register. The frame length comes from the `frame_words` input. The block sends that many words, taken one at a time from a valid/ready pixel stream. When the last word is finished, a sticky done interrupt is raised, and software clears it by writing one to it. A trigger written while a frame is in flight is dropped, because a second start would disturb the panel. Frames go out only on software triggers; there is no self-refresh timer.

Top module: `i80_wr_if`

## Requirements
- R1: After reset, `cs_n` and `wr_n` are 1, `rs`, `irq_done` and `pix_ready` are 0, `db` is 0 and all registers read 0.
- R2: Bit 0 of the timing register (address 0) is the enable. While it is 0, `cs_n` and `wr_n` stay 1 and no frame starts. Clearing it during a frame ends the frame at once, and no interrupt is raised.
- R3: The timing register sets the phase lengths: CS setup in bits 19:16, WR setup in bits 15:12, WR active in bits 11:8 and WR hold in bits 7:4. One word holds `cs_n` low for (CS setup+1) cycles, then (WR setup+1) cycles with `wr_n` high, then (WR active+1) cycles with `wr_n` low, then (WR hold+1) cycles with `wr_n` high. After that, `cs_n` is high for exactly one cycle before the next word.
- R4: `db` shows the accepted pixel word from the first WR-setup cycle until the end of the hold phase, and does not change during those phases.
- R5: `pix_ready` is 1 only in the last CS-setup cycle. If `pix_valid` is 0 there, the block stays in that cycle until a word is offered.
- R6: The trigger register (address 1) holds the mode in bit 0 and the software trigger in bit 1. A frame starts only when enable, mode and trigger are all 1. The trigger bit then reads 0 from the cycle after the start. With mode 0, the trigger bit stays set and nothing is sent.
- R7: `irq_done` (address 2, bit 0) is set in the cycle after the last word's hold phase ends. It stays set until software writes 1 to bit 0 of address 2. If a completion and a clear fall in the same cycle, the completion wins.
- R8: A trigger written while a frame is in flight is dropped: the trigger bit reads 0 and no extra frame follows.
- R9: A frame sends exactly `frame_words` words, sampled at the start, and `rs` is 1 for the whole frame. A frame of 0 words raises `irq_done` without any bus cycle.
- R10: `reg_rdata` returns the register selected by `reg_addr` in the same cycle. Address 0 returns the timing word as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 timing, 1 trigger, 2 interrupt) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| frame_words | input | LENW | Number of words in the next frame |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Pixel word taken this cycle |
| pix_data | input | DW | Pixel word |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| rs | output | 1 | Register select, high for data during a frame |
| db | output | DW | Panel data bus |
| irq_done | output | 1 | Sticky frame-done interrupt |

## Verification
The assertions check these properties on every cycle: the write strobe is low only inside chip select, the data bus does not change once a word has been captured, ready is raised only in a setup cycle, the trigger bit reads clear for as long as a frame runs, and the interrupt only rises when a frame ends. The exact phase lengths, the one idle cycle between words, the word count, stalls on the pixel stream, abort by disable, zero-length frames and the mode gating of the trigger can only be shown by the bench scenarios. There, a behavioural model is compared with the outputs on every cycle, and the bench also counts the strobes sent and reads back the registers.

// File: rtl/i80_pkg.sv
package i80_pkg;
   localparam int PHW = 4;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CSS  = 3'd1,
      PH_WRS  = 3'd2,
      PH_WRA  = 3'd3,
      PH_WRH  = 3'd4
   } phase_e;

   typedef struct packed {
      logic [PHW-1:0] css;
      logic [PHW-1:0] wrs;
      logic [PHW-1:0] wra;
      logic [PHW-1:0] wrh;
      logic           en;
   } timing_t;

   localparam logic [1:0] ADDR_TIMING = 2'd0;
   localparam logic [1:0] ADDR_TRIG   = 2'd1;
   localparam logic [1:0] ADDR_IRQ    = 2'd2;

   function automatic timing_t unpack_timing(input logic [31:0] w);
      timing_t t;
      t.css = w[19:16];
      t.wrs = w[15:12];
      t.wra = w[11:8];
      t.wrh = w[7:4];
      t.en  = w[0];
      return t;
   endfunction
endpackage

// File: rtl/i80_regs.sv
module i80_regs
   import i80_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   input  logic        start,
   input  logic        fin,
   input  logic        busy,
   output timing_t     tim,
   output logic        mode,
   output logic        trig,
   output logic        irq
);
   logic [31:0] tim_word_q;
   logic        mode_q, trig_q, irq_q;
   logic        clr_req;

   assign clr_req = wr_en && (addr == ADDR_IRQ) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tim_word_q <= '0;
         mode_q     <= 1'b0;
         trig_q     <= 1'b0;
         irq_q      <= 1'b0;
      end else begin
         if (wr_en && addr == ADDR_TIMING)
            tim_word_q <= wdata;
         if (wr_en && addr == ADDR_TRIG) begin
            mode_q <= wdata[0];
            if (!busy)
               trig_q <= wdata[1];
         end
         if (start)
            trig_q <= 1'b0;
         if (fin)
            irq_q <= 1'b1;
         else if (clr_req)
            irq_q <= 1'b0;
      end
   end

   always_comb begin
      case (addr)
         ADDR_TIMING: rdata = tim_word_q;
         ADDR_TRIG:   rdata = {30'd0, trig_q, mode_q};
         ADDR_IRQ:    rdata = {31'd0, irq_q};
         default:     rdata = 32'd0;
      endcase
   end

   assign tim  = unpack_timing(tim_word_q);
   assign mode = mode_q;
   assign trig = trig_q;
   assign irq  = irq_q;

   // R7: pending bit is sticky until a write-one clear
   a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr_req) |=> irq_q);
endmodule

// File: rtl/i80_frame_ctl.sv
module i80_frame_ctl #(
   parameter int LENW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            mode,
   input  logic            trig,
   input  logic [LENW-1:0] frame_words,
   input  logic            seq_idle,
   output logic            start,
   output logic            go,
   output logic            fin,
   output logic            busy
);
   localparam logic [LENW-1:0] ONE = {{(LENW-1){1'b0}}, 1'b1};

   logic            busy_q;
   logic [LENW-1:0] rem_q;

   assign start = !busy_q && en && mode && trig;
   assign go    = busy_q && en && seq_idle && (rem_q != '0);
   assign fin   = busy_q && en && seq_idle && (rem_q == '0);
   assign busy  = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rem_q  <= '0;
      end else if (busy_q && !en) begin
         busy_q <= 1'b0;
         rem_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         rem_q  <= frame_words;
      end else if (go) begin
         rem_q  <= rem_q - ONE;
      end else if (fin) begin
         busy_q <= 1'b0;
      end
   end

   // R2: dropping the enable ends a running frame
   a_r2_abort_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy_q);
   // R9: the count never moves while the controller is idle
   a_r9_rem_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start && $past(!busy_q)) |=> $stable(rem_q));
endmodule

// File: rtl/i80_phase_seq.sv
module i80_phase_seq
   import i80_pkg::*;
#(
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  timing_t       tim,
   input  logic          go,
   input  logic          pix_valid,
   input  logic [DW-1:0] pix_data,
   output logic          pix_ready,
   output logic          cs_n,
   output logic          wr_n,
   output logic [DW-1:0] data,
   output logic          idle
);
   phase_e         ph_q;
   logic [PHW-1:0] cnt_q;
   logic [PHW-1:0] lim;
   logic           at_lim;
   logic [DW-1:0]  data_q;

   always_comb begin
      case (ph_q)
         PH_CSS:  lim = tim.css;
         PH_WRS:  lim = tim.wrs;
         PH_WRA:  lim = tim.wra;
         PH_WRH:  lim = tim.wrh;
         default: lim = '0;
      endcase
   end

   assign at_lim = (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else if (!tim.en) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: if (go) begin
               ph_q  <= PH_CSS;
               cnt_q <= '0;
            end
            PH_CSS: if (!at_lim) begin
               cnt_q <= cnt_q + 1'b1;
            end else if (pix_valid) begin
               ph_q  <= PH_WRS;
               cnt_q <= '0;
            end
            PH_WRS: if (at_lim) begin
               ph_q  <= PH_WRA;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            PH_WRA: if (at_lim) begin
               ph_q  <= PH_WRH;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            PH_WRH: if (at_lim) begin
               ph_q  <= PH_IDLE;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            default: begin
               ph_q  <= PH_IDLE;
               cnt_q <= '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= '0;
      else if (tim.en && ph_q == PH_CSS && at_lim && pix_valid)
         data_q <= pix_data;
   end

   assign pix_ready = tim.en && (ph_q == PH_CSS) && at_lim;
   assign cs_n      = (ph_q == PH_IDLE);
   assign wr_n      = (ph_q != PH_WRA);
   assign data      = data_q;
   assign idle      = (ph_q == PH_IDLE);

   // R3: the strobe only pulses inside chip select
   a_r3_wr_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !cs_n);
   // R4: captured word held through setup, active and hold
   a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && $past(ph_q) != PH_CSS) |-> $stable(data_q));
   // R5: ready only while the strobe is high inside chip select
   a_r5_ready_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready |-> (!cs_n && wr_n));
   // R2: a cleared enable leaves the bus idle next cycle
   a_r2_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !tim.en |=> (cs_n && wr_n));
endmodule

// File: rtl/i80_wr_if.sv
module i80_wr_if
   import i80_pkg::*;
#(
   parameter int DW        = 24,
   parameter int LENW      = 16,
   parameter bit HOLD_IDLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [1:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic [LENW-1:0] frame_words,
   input  logic            pix_valid,
   output logic            pix_ready,
   input  logic [DW-1:0]   pix_data,
   output logic            cs_n,
   output logic            wr_n,
   output logic            rs,
   output logic [DW-1:0]   db,
   output logic            irq_done
);
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("DW must be in 1..32");
   end
   if (LENW < 1 || LENW > 31) begin : g_bad_lenw
      $error("LENW must be in 1..31");
   end

   timing_t       tim;
   logic          mode, trig, irq;
   logic          start, go, fin, busy, seq_idle;
   logic [DW-1:0] seq_data;

   i80_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .start(start), .fin(fin),
      .busy(busy), .tim(tim), .mode(mode), .trig(trig), .irq(irq)
   );

   i80_frame_ctl #(.LENW(LENW)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(tim.en), .mode(mode), .trig(trig),
      .frame_words(frame_words), .seq_idle(seq_idle), .start(start),
      .go(go), .fin(fin), .busy(busy)
   );

   i80_phase_seq #(.DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .tim(tim), .go(go), .pix_valid(pix_valid),
      .pix_data(pix_data), .pix_ready(pix_ready), .cs_n(cs_n), .wr_n(wr_n),
      .data(seq_data), .idle(seq_idle)
   );

   if (HOLD_IDLE) begin : g_db_hold
      assign db = seq_data;
   end else begin : g_db_zero
      assign db = busy ? seq_data : '0;
   end

   assign rs       = busy;
   assign irq_done = irq;

   // R8: no trigger can be pending while a frame runs
   a_r8_no_trig_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !trig);
   // R7: the interrupt rises only as a frame ends
   a_r7_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(busy));
   // R9: bus activity only inside a frame
   a_r9_cs_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);
endmodule

// File: tb/i80_wr_if_bench.sv
module i80_wr_if_bench;
   localparam int DW   = 24;
   localparam int LENW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic [1:0]      reg_addr = 2'd0;
   logic [31:0]     reg_wdata = 32'd0;
   logic [31:0]     reg_rdata;
   logic [LENW-1:0] frame_words = '0;
   logic            pix_ready;
   logic            cs_n, wr_n, rs, irq_done;
   logic [DW-1:0]   db;

   logic [DW-1:0]   q[$];
   logic            stall_en = 1'b0;
   logic            stall_tgl = 1'b0;
   logic            pix_valid;
   logic [DW-1:0]   pix_data;

   assign pix_valid = (q.size() > 0) && !(stall_en && stall_tgl);
   assign pix_data  = (q.size() > 0) ? q[0] : '0;

   always #10 clk = ~clk;

   i80_wr_if u_i80_wr_if (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_words(frame_words),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
      .cs_n(cs_n), .wr_n(wr_n), .rs(rs), .db(db), .irq_done(irq_done)
   );

   int nchk = 0;
   int nerr = 0;
   int words = 0;
   bit done_flag = 0;

   // behavioural reference: phase 0 idle,1 cs setup,2 wr setup,3 wr active,4 hold
   int          m_ph, m_cnt, m_rem;
   bit          m_busy, m_mode, m_trig, m_irq, pop_req;
   logic [31:0] m_tim;
   logic [DW-1:0] m_db;

   function automatic int lim_of(int ph, logic [31:0] t);
      case (ph)
         1: return int'(t[19:16]);
         2: return int'(t[15:12]);
         3: return int'(t[11:8]);
         4: return int'(t[7:4]);
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_rem = 0; m_busy = 0; m_mode = 0;
         m_trig = 0; m_irq = 0; m_tim = 0; m_db = 0; pop_req = 0;
      end else begin
         bit en, s, g, f;
         int n_ph, n_cnt, n_rem;
         bit n_busy, n_mode, n_trig, n_irq;
         logic [31:0] n_tim;
         logic [DW-1:0] n_db;
         en = m_tim[0];
         s = !m_busy && en && m_mode && m_trig;
         g = m_busy && en && m_ph == 0 && m_rem != 0;
         f = m_busy && en && m_ph == 0 && m_rem == 0;
         n_ph = m_ph; n_cnt = m_cnt; n_rem = m_rem; n_busy = m_busy;
         n_mode = m_mode; n_trig = m_trig; n_irq = m_irq; n_tim = m_tim; n_db = m_db;
         if (!en) begin
            n_ph = 0; n_cnt = 0;
         end else if (m_ph == 0) begin
            if (g) begin n_ph = 1; n_cnt = 0; end
         end else if (m_cnt != lim_of(m_ph, m_tim)) begin
            n_cnt = m_cnt + 1;
         end else if (m_ph == 1) begin
            if (pix_valid) begin n_db = pix_data; n_ph = 2; n_cnt = 0; pop_req = 1; end
         end else begin
            n_ph = (m_ph == 4) ? 0 : m_ph + 1; n_cnt = 0;
         end
         if (m_busy && !en) begin n_busy = 0; n_rem = 0; end
         else if (s) begin n_busy = 1; n_rem = int'(frame_words); end
         else if (g) n_rem = m_rem - 1;
         else if (f) n_busy = 0;
         if (reg_wr) begin
            if (reg_addr == 2'd0) n_tim = reg_wdata;
            if (reg_addr == 2'd1) begin
               n_mode = reg_wdata[0];
               if (!m_busy) n_trig = reg_wdata[1];
            end
            if (reg_addr == 2'd2 && reg_wdata[0]) n_irq = 0;
         end
         if (s) n_trig = 0;
         if (f) n_irq = 1;
         m_ph = n_ph; m_cnt = n_cnt; m_rem = n_rem; m_busy = n_busy; m_mode = n_mode;
         m_trig = n_trig; m_irq = n_irq; m_tim = n_tim; m_db = n_db;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   logic prev_wr_n = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 cs_n", cs_n, m_ph == 0);
         chk("R3 wr_n", wr_n, m_ph != 3);
         chk("R9 rs", rs, m_busy);
         chk("R4 db", db, m_db);
         chk("R5 pix_ready", pix_ready, m_tim[0] && m_ph == 1 && m_cnt == lim_of(1, m_tim));
         chk("R7 irq_done", irq_done, m_irq);
         if (wr_n && !prev_wr_n) words++;
      end
      prev_wr_n = wr_n;
      if (pop_req) begin
         if (q.size() > 0) void'(q.pop_front());
         pop_req = 0;
      end
      stall_tgl = ~stall_tgl;
   end

   task automatic wreg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rchk(input string tag, input logic [1:0] a, input logic [31:0] e);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, e);
   endtask

   task automatic wait_irq(input string tag);
      int n = 0;
      while (!irq_done && n < 2000) begin @(negedge clk); n++; end
      chk(tag, irq_done, 1);
   endtask

   task automatic fill(input int n, input int base);
      for (int i = 0; i < n; i++) q.push_back(DW'(base + i * 24'h010203));
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      int w0;
      repeat (3) @(negedge clk);
      // R1 reset values
      chk("R1 cs_n", cs_n, 1); chk("R1 wr_n", wr_n, 1); chk("R1 rs", rs, 0);
      chk("R1 irq", irq_done, 0); chk("R1 ready", pix_ready, 0); chk("R1 db", db, 0);
      rchk("R1 timing", 2'd0, 0); rchk("R1 trig", 2'd1, 0); rchk("R1 irq reg", 2'd2, 0);
      @(negedge clk); rst_n = 1'b1;

      // R2: trigger with enable clear does nothing
      frame_words = 16'd2; fill(2, 24'h100000);
      wreg(2'd1, 32'h3);
      repeat (10) @(negedge clk);
      chk("R2 no frame when disabled", words, 0);
      chk("R2 bus idle", cs_n, 1);

      // R3 R6 R9 R10: normal frame, mixed phase lengths (trig still pending)
      wreg(2'd0, 32'h0002_3151);
      rchk("R10 timing readback", 2'd0, 32'h0002_3151);
      wait_irq("R7 done after frame 1");
      chk("R9 words frame 1", words, 2);
      rchk("R6 trig self clear", 2'd1, 32'h1);
      wreg(2'd2, 32'h1);
      rchk("R7 w1c clear", 2'd2, 0);

      // R5: zero phases with stalling stream
      w0 = words; stall_en = 1'b1;
      frame_words = 16'd4; fill(4, 24'h200001);
      wreg(2'd0, 32'h0000_0001);
      wreg(2'd1, 32'h3);
      wait_irq("R5 done with stalls");
      chk("R5 words with stalls", words - w0, 4);
      chk("R5 stream drained", q.size(), 0);
      stall_en = 1'b0;
      wreg(2'd2, 32'h1);

      // R8: trigger during a long frame is dropped
      w0 = words; frame_words = 16'd3; fill(3, 24'h300002);
      wreg(2'd0, 32'h000F_3A51);
      wreg(2'd1, 32'h3);
      repeat (20) @(negedge clk);
      wreg(2'd1, 32'h3);
      rchk("R8 trig reads 0 in flight", 2'd1, 32'h1);
      wait_irq("R8 done");
      wreg(2'd2, 32'h1);
      repeat (60) @(negedge clk);
      chk("R8 no second frame", words - w0, 3);
      chk("R8 irq stays clear", irq_done, 0);

      // R9: zero-length frame
      w0 = words; frame_words = 16'd0;
      wreg(2'd1, 32'h3);
      wait_irq("R9 zero length done");
      chk("R9 zero length no words", words - w0, 0);
      wreg(2'd2, 32'h1);

      // R6: mode clear keeps trigger pending
      w0 = words; frame_words = 16'd1; fill(1, 24'h400003);
      wreg(2'd0, 32'h0001_1111);
      wreg(2'd1, 32'h2);
      repeat (10) @(negedge clk);
      rchk("R6 trig pending with mode 0", 2'd1, 32'h2);
      chk("R6 no words with mode 0", words - w0, 0);
      wreg(2'd1, 32'h3);
      wait_irq("R6 frame after mode set");
      chk("R6 one word", words - w0, 1);
      wreg(2'd2, 32'h1);

      // R2: abort by clearing enable mid-frame
      frame_words = 16'd5; fill(5, 24'h500004);
      wreg(2'd0, 32'h0003_3331);
      wreg(2'd1, 32'h3);
      repeat (25) @(negedge clk);
      wreg(2'd0, 32'h0003_3330);
      repeat (10) @(negedge clk);
      chk("R2 abort no irq", irq_done, 0);
      chk("R2 abort rs low", rs, 0);
      q.delete();
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule